// File: doc/BRIEF.md
# Bufferless deflection mesh router

This block is one node router for a two-dimensional mesh. It has no flit storage. Every flit that enters in a cycle leaves on some output in the same routing pass. When two flits want the same direction, the loser is sent out on another free link (deflected) instead of waiting. Each flit carries its own header: destination column, destination row and an age. Flits of one packet may therefore travel apart.

The router has four neighbour links (north, east, south, west), one local ejection output and one local injection input with an accept signal. Flits pass through two registered stages. The first stage registers the incoming flits and their productive directions. The second stage ranks the flits by age, gives each one a port in turn, and registers the switch outputs. The node's own column and row are parameters.

A flit word is `{valid, dest_x[2:0], dest_y[2:0], age[7:0], payload[127:0]}`, with the valid bit at the top. Row numbers grow toward north and column numbers grow toward east.

Top module: `bl_defl_router`

## Requirements
- R1: In every cycle, the number of valid flits on the four neighbour outputs plus the ejection output equals the number of flits accepted into the router two cycles earlier. Accepted flits are the valid neighbour inputs plus an injected flit. No flit is dropped or held.
- R2: A flit presented before clock edge k appears on its output register after edge k+1. Its word `{valid, dest_x, dest_y, age, payload}` is unchanged.
- R3: A flit is productive toward the following directions:
  - north (out_n) when dest_y is above its own row;
  - south when dest_y is below its own row;
  - east when dest_x is above its own column;
  - west when dest_x is below its own column.

  If more than one productive output is free, the first free one in the order north, east, south, west is taken.
- R4: Ports are given out one flit at a time, from the largest age down. Equal ages are ordered by input: north, then east, then south, then west, then the local input.
- R5: A flit that finds no free productive output goes to the first free neighbour output in the order north, east, south, west. The matching bit of out_defl (bit 0 north, 1 east, 2 south, 3 west) is then 1. For a productive flit or an idle output, that bit is 0.
- R6: A flit whose destination equals the router's own coordinates leaves on out_ej if the ejection output is still free when its turn comes. Only one flit is ejected per cycle, the highest-ranked one. Other flits addressed to this router are deflected onto neighbour outputs.
- R7: inj_ready is 1 exactly when fewer than four neighbour inputs carry a valid flit. An injected word is taken only when inj_valid and inj_ready are both 1. Otherwise it never appears on any output.
- R8: While reset is applied, all outputs are invalid, out_defl is 0 and inj_ready is 0. After release, an idle router shows inj_ready 1 and invalid outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| in_n | input | 143 | Flit arriving from the north neighbour |
| in_e | input | 143 | Flit arriving from the east neighbour |
| in_s | input | 143 | Flit arriving from the south neighbour |
| in_w | input | 143 | Flit arriving from the west neighbour |
| inj_flit | input | 142 | Local flit to inject, without the valid bit |
| inj_valid | input | 1 | Local flit offered this cycle |
| inj_ready | output | 1 | Router can take the local flit this cycle |
| out_n | output | 143 | Flit leaving toward the north |
| out_e | output | 143 | Flit leaving toward the east |
| out_s | output | 143 | Flit leaving toward the south |
| out_w | output | 143 | Flit leaving toward the west |
| out_ej | output | 143 | Flit delivered to the local node |
| out_defl | output | 4 | Per-neighbour-output flag: flit was deflected |

## Verification
Ejection can fall in the same cycle as a deflection. When two flits addressed to this node arrive together with a third flit that is passing through, the older local flit must reach out_ej. The younger one must be pushed onto the first free neighbour link, with its flag set. The passing flit must keep its productive link.

Injection can also coincide with ejection. In that case three neighbour flits arrive alongside an injected flit that is addressed to this node, so the injected flit must be ejected while the other three go out productively.

Each case is judged output by output against words and flags computed by hand, two cycles after the stimulus. The per-cycle flit count confirms that nothing vanished.

// File: rtl/bl_pkg.sv
package bl_pkg;
  localparam int XW   = 3;
  localparam int YW   = 3;
  localparam int AGEW = 8;
  localparam int DW   = 128;
  localparam int HW   = 1 + XW + YW + AGEW;   // header incl. valid
  localparam int FW   = HW + DW;
  localparam int NNB  = 4;                    // neighbour links
  localparam int NIN  = NNB + 1;              // plus local injection
  localparam int NOUT = NNB + 1;              // plus local ejection
  localparam int RW   = $clog2(NIN);
  localparam int PN   = 0;
  localparam int PE   = 1;
  localparam int PS   = 2;
  localparam int PW   = 3;
  localparam int PL   = 4;

  typedef struct packed {
    logic            valid;
    logic [XW-1:0]   dx;
    logic [YW-1:0]   dy;
    logic [AGEW-1:0] age;
    logic [DW-1:0]   data;
  } flit_t;
endpackage

// File: rtl/bl_route_calc.sv
module bl_route_calc
  import bl_pkg::*;
#(
  parameter int unsigned MY_X = 3,
  parameter int unsigned MY_Y = 3
) (
  input  logic           valid,
  input  logic [XW-1:0]  dx,
  input  logic [YW-1:0]  dy,
  output logic [NNB-1:0] prod,
  output logic           here
);
  localparam logic [XW-1:0] MX = XW'(MY_X);
  localparam logic [YW-1:0] MY = YW'(MY_Y);

  always_comb begin
    prod     = '0;
    prod[PN] = valid && (dy > MY);
    prod[PE] = valid && (dx > MX);
    prod[PS] = valid && (dy < MY);
    prod[PW] = valid && (dx < MX);
    here     = valid && (dx == MX) && (dy == MY);
  end
endmodule

// File: rtl/bl_rank.sv
module bl_rank
  import bl_pkg::*;
(
  input  logic [NIN-1:0]           vld,
  input  logic [NIN-1:0][AGEW-1:0] age,
  output logic [NIN-1:0][RW-1:0]   rank
);
  // beat[i][j]: flit j is ranked ahead of flit i
  logic [NIN-1:0] beat [NIN];

  for (genvar i = 0; i < NIN; i++) begin : g_row
    for (genvar j = 0; j < NIN; j++) begin : g_col
      if (i == j) begin : g_self
        assign beat[i][j] = 1'b0;
      end else if (j < i) begin : g_pri
        assign beat[i][j] = vld[j] && (age[j] >= age[i]);
      end else begin : g_sub
        assign beat[i][j] = vld[j] && (age[j] > age[i]);
      end
    end
    assign rank[i] = RW'($countones(beat[i]));
  end
endmodule

// File: rtl/bl_port_alloc.sv
module bl_port_alloc
  import bl_pkg::*;
(
  input  logic            req,
  input  logic [NNB-1:0]  prod,
  input  logic            here,
  input  logic [NOUT-1:0] free_in,
  output logic [NOUT-1:0] grant,
  output logic            defl,
  output logic [NOUT-1:0] free_out
);
  logic [NNB-1:0] avail;
  logic [NNB-1:0] nb_free;

  always_comb begin
    nb_free = free_in[NNB-1:0];
    avail   = prod & nb_free;
    grant   = '0;
    defl    = 1'b0;
    if (req) begin
      if (here && free_in[PL]) begin
        grant[PL] = 1'b1;
      end else if (|avail) begin
        grant[NNB-1:0] = avail & (~avail + NNB'(1));
      end else begin
        grant[NNB-1:0] = nb_free & (~nb_free + NNB'(1));
        defl           = 1'b1;
      end
    end
    free_out = free_in & ~grant;
  end
endmodule

// File: rtl/bl_defl_router.sv
module bl_defl_router
  import bl_pkg::*;
#(
  parameter int unsigned MY_X = 3,
  parameter int unsigned MY_Y = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] in_n,
  input  logic [FW-1:0] in_e,
  input  logic [FW-1:0] in_s,
  input  logic [FW-1:0] in_w,
  input  logic [FW-2:0] inj_flit,
  input  logic          inj_valid,
  output logic          inj_ready,
  output logic [FW-1:0] out_n,
  output logic [FW-1:0] out_e,
  output logic [FW-1:0] out_s,
  output logic [FW-1:0] out_w,
  output logic [FW-1:0] out_ej,
  output logic [NNB-1:0] out_defl
);
  localparam logic [XW-1:0] MX = XW'(MY_X);
  localparam logic [YW-1:0] MY = YW'(MY_Y);

  // ---------------- reset release synchroniser
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  // ---------------- injection gate
  logic [NNB-1:0] nb_valid;
  logic           inj_take;

  assign nb_valid  = {in_w[FW-1], in_s[FW-1], in_e[FW-1], in_n[FW-1]};
  assign inj_ready = core_rst_n & ~(&nb_valid);
  assign inj_take  = inj_valid & inj_ready;

  logic [NIN-1:0][FW-1:0] arr_in;
  assign arr_in = {{inj_take, inj_flit}, in_w, in_s, in_e, in_n};

  // ---------------- stage 1: route computation
  logic [NIN-1:0][NNB-1:0] rc_prod;
  logic [NIN-1:0]          rc_here;

  for (genvar i = 0; i < NIN; i++) begin : g_rc
    bl_route_calc #(.MY_X(MY_X), .MY_Y(MY_Y)) u_rc (
      .valid (arr_in[i][FW-1]),
      .dx    (arr_in[i][FW-2 -: XW]),
      .dy    (arr_in[i][FW-2-XW -: YW]),
      .prod  (rc_prod[i]),
      .here  (rc_here[i])
    );
  end

  logic [NIN-1:0][HW-1:0]  s1_hdr_d, s1_hdr_q;
  logic [NIN-1:0][DW-1:0]  s1_dat_q;
  logic [NIN-1:0][NNB-1:0] s1_prod_q;
  logic [NIN-1:0]          s1_here_q;
  logic [NIN-1:0]          s1_den;

  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      s1_den[i]   = arr_in[i][FW-1];
      s1_hdr_d[i] = s1_den[i] ? arr_in[i][FW-1 -: HW] : '0;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      s1_hdr_q  <= '0;
      s1_prod_q <= '0;
      s1_here_q <= '0;
    end else begin
      s1_hdr_q  <= s1_hdr_d;
      s1_prod_q <= rc_prod;
      s1_here_q <= rc_here;
    end
  end

  // payload only loads when a flit is present
  always_ff @(posedge clk) begin
    for (int i = 0; i < NIN; i++) begin
      if (s1_den[i]) s1_dat_q[i] <= arr_in[i][DW-1:0];
    end
  end

  // ---------------- stage 2: rank, allocate, traverse
  logic [NIN-1:0]           s1_vld;
  logic [NIN-1:0][AGEW-1:0] s1_age;
  logic [NIN-1:0][RW-1:0]   s1_rank;

  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      s1_vld[i] = s1_hdr_q[i][HW-1];
      s1_age[i] = s1_hdr_q[i][AGEW-1:0];
    end
  end

  bl_rank u_rank (.vld(s1_vld), .age(s1_age), .rank(s1_rank));

  logic [NIN-1:0]  sel     [NIN];
  logic            st_req  [NIN];
  logic [NNB-1:0]  st_prod [NIN];
  logic            st_here [NIN];
  logic [NOUT-1:0] st_grant[NIN];
  logic            st_defl [NIN];
  logic [NOUT-1:0] free_ch [NIN+1];

  always_comb begin
    for (int r = 0; r < NIN; r++) begin
      st_req[r]  = 1'b0;
      st_prod[r] = '0;
      st_here[r] = 1'b0;
      for (int i = 0; i < NIN; i++) begin
        sel[r][i] = s1_vld[i] && (s1_rank[i] == RW'(r));
        if (sel[r][i]) begin
          st_req[r]  = 1'b1;
          st_prod[r] = st_prod[r] | s1_prod_q[i];
          st_here[r] = st_here[r] | s1_here_q[i];
        end
      end
    end
  end

  assign free_ch[0] = '1;

  for (genvar r = 0; r < NIN; r++) begin : g_alloc
    bl_port_alloc u_pa (
      .req      (st_req[r]),
      .prod     (st_prod[r]),
      .here     (st_here[r]),
      .free_in  (free_ch[r]),
      .grant    (st_grant[r]),
      .defl     (st_defl[r]),
      .free_out (free_ch[r+1])
    );
  end

  logic [NOUT-1:0]          flit_grant [NIN];
  logic [NOUT-1:0][FW-1:0]  out_d, out_q;
  logic [NNB-1:0]           defl_d, defl_q;

  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      flit_grant[i] = '0;
      for (int r = 0; r < NIN; r++) begin
        if (sel[r][i]) flit_grant[i] = flit_grant[i] | st_grant[r];
      end
    end
    for (int o = 0; o < NOUT; o++) begin
      out_d[o] = '0;
      for (int i = 0; i < NIN; i++) begin
        if (flit_grant[i][o]) out_d[o] = out_d[o] | {s1_hdr_q[i], s1_dat_q[i]};
      end
    end
    for (int o = 0; o < NNB; o++) begin
      defl_d[o] = 1'b0;
      for (int r = 0; r < NIN; r++) begin
        defl_d[o] = defl_d[o] | (st_grant[r][o] & st_defl[r]);
      end
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      out_q  <= '0;
      defl_q <= '0;
    end else begin
      out_q  <= out_d;
      defl_q <= defl_d;
    end
  end

  assign out_n    = out_q[PN];
  assign out_e    = out_q[PE];
  assign out_s    = out_q[PS];
  assign out_w    = out_q[PW];
  assign out_ej   = out_q[PL];
  assign out_defl = defl_q;

  // ---------------- assertions
  int s1_cnt, out_cnt, grant_cnt;
  logic [NOUT-1:0] grant_union;

  always_comb begin
    s1_cnt      = $countones(s1_vld);
    out_cnt     = 0;
    grant_union = '0;
    for (int o = 0; o < NOUT; o++) out_cnt = out_cnt + int'(out_q[o][FW-1]);
    for (int i = 0; i < NIN; i++) grant_union = grant_union | flit_grant[i];
    grant_cnt   = $countones(grant_union);
  end

  a_r1_conserve: assert property (@(posedge clk) disable iff (!core_rst_n)
    $past(core_rst_n) |-> (out_cnt == $past(s1_cnt)));

  a_r7_slot_cap: assert property (@(posedge clk) disable iff (!core_rst_n)
    s1_cnt <= NNB);

  a_r6_eject_here: assert property (@(posedge clk) disable iff (!core_rst_n)
    out_q[PL][FW-1] |-> (out_q[PL][FW-2 -: XW] == MX && out_q[PL][FW-2-XW -: YW] == MY));

  a_r1_no_collision: assert property (@(posedge clk) disable iff (!core_rst_n)
    grant_cnt == s1_cnt);

  a_r4_oldest_productive: assert property (@(posedge clk) disable iff (!core_rst_n)
    (st_req[0] && (|st_prod[0])) |-> !st_defl[0]);

  for (genvar i = 0; i < NIN; i++) begin : g_chk
    a_r1_each_placed: assert property (@(posedge clk) disable iff (!core_rst_n)
      s1_vld[i] |-> $onehot(flit_grant[i]));
    a_r1_idle_unplaced: assert property (@(posedge clk) disable iff (!core_rst_n)
      !s1_vld[i] |-> (flit_grant[i] == '0));
  end
endmodule

// File: tb/sim_bl_defl_router.sv
`timescale 1ns/1ps
module sim_bl_defl_router;
  import bl_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [FW-1:0]  din [NIN];
  logic           inj_valid;
  logic           inj_ready;
  logic [FW-1:0]  out_n, out_e, out_s, out_w, out_ej;
  logic [NNB-1:0] out_defl;

  bl_defl_router #(.MY_X(3), .MY_Y(3)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_n(din[PN]), .in_e(din[PE]), .in_s(din[PS]), .in_w(din[PW]),
    .inj_flit(din[PL][FW-2:0]), .inj_valid(inj_valid), .inj_ready(inj_ready),
    .out_n(out_n), .out_e(out_e), .out_s(out_s), .out_w(out_w), .out_ej(out_ej),
    .out_defl(out_defl)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_on = 1'b0;

  typedef struct {
    int            due;
    int            port;
    logic [FW-1:0] f;
    logic          defl;
    string         req;
  } exp_t;

  exp_t q[$];
  int   exp_cnt[int];

  function automatic logic [FW-1:0] mk(int dx, int dy, int age, logic [DW-1:0] pl);
    flit_t t;
    t.valid = 1'b1;
    t.dx    = dx[XW-1:0];
    t.dy    = dy[YW-1:0];
    t.age   = age[AGEW-1:0];
    t.data  = pl;
    return t;
  endfunction

  function automatic logic [FW-1:0] get_out(int p);
    case (p)
      PN: return out_n;
      PE: return out_e;
      PS: return out_s;
      PW: return out_w;
      default: return out_ej;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [FW-1:0] act, logic [FW-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // ---------------- monitor: pop due expectations and count flits
  always @(negedge clk) begin
    int k, ac, ec;
    logic [FW-1:0] a;
    if (mon_on) begin
      k = 0;
      while (k < q.size()) begin
        if (q[k].due == cyc) begin
          a = get_out(q[k].port);
          if (q[k].f[FW-1])
            chk(q[k].req, $sformatf("port %0d word", q[k].port), a, q[k].f);
          else
            chk(q[k].req, $sformatf("port %0d valid", q[k].port), FW'(a[FW-1]), '0);
          if (q[k].port < NNB)
            chk(q[k].req, $sformatf("port %0d deflect flag", q[k].port),
                FW'(out_defl[q[k].port]), FW'(q[k].defl));
          q.delete(k);
        end else begin
          k++;
        end
      end
      ac = int'(out_n[FW-1]) + int'(out_e[FW-1]) + int'(out_s[FW-1])
         + int'(out_w[FW-1]) + int'(out_ej[FW-1]);
      ec = exp_cnt.exists(cyc) ? exp_cnt[cyc] : 0;
      chk("R1", "flit count", FW'(ac), FW'(ec));
    end
  end

  // ---------------- driver tasks
  task automatic clear_in();
    for (int k = 0; k < NIN; k++) din[k] = '0;
    inj_valid = 1'b0;
  endtask

  task automatic put(int port, int dx, int dy, int age, logic [DW-1:0] pl);
    din[port] = mk(dx, dy, age, pl);
    if (port == PL) inj_valid = 1'b1;
  endtask

  task automatic want(int port, int dx, int dy, int age, logic [DW-1:0] pl,
                      logic defl, string req);
    exp_t e;
    e.due = cyc + 2; e.port = port; e.f = mk(dx, dy, age, pl);
    e.defl = defl; e.req = req;
    q.push_back(e);
  endtask

  task automatic want_none(int port, string req);
    exp_t e;
    e.due = cyc + 2; e.port = port; e.f = '0; e.defl = 1'b0; e.req = req;
    q.push_back(e);
  endtask

  task automatic launch();
    int  nb;
    bit  rdy;
    nb = 0;
    for (int k = 0; k < NNB; k++) nb += int'(din[k][FW-1]);
    rdy = (nb < NNB);
    #0.5;
    chk("R7", "inj_ready", FW'(inj_ready), FW'(rdy));
    exp_cnt[cyc + 2] = nb + ((inj_valid && rdy) ? 1 : 0);
    @(negedge clk);
    clear_in();
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // ---------------- watchdog
  initial begin
    #500000;
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog: actual running expected finished");
    report();
    $finish;
  end

  // ---------------- stimulus
  initial begin
    clear_in();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R8: state under reset
    for (int p = 0; p < NOUT; p++) chk("R8", "valid in reset", FW'(get_out(p)[FW-1]), '0);
    chk("R8", "defl in reset", FW'(out_defl), '0);
    chk("R8", "inj_ready in reset", FW'(inj_ready), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8", "inj_ready idle", FW'(inj_ready), FW'(1));
    for (int p = 0; p < NOUT; p++) chk("R8", "valid idle", FW'(get_out(p)[FW-1]), '0);
    mon_on = 1'b1;

    // R2/R3: lone flit heading east
    put(PW, 5, 3, 10, {4{32'hA5A5_0001}});
    want(PE, 5, 3, 10, {4{32'hA5A5_0001}}, 1'b0, "R2");
    want_none(PN, "R2"); want_none(PS, "R2"); want_none(PW, "R2"); want_none(PL, "R2");
    launch();

    // R3/R7: four distinct productive routes, local rejected
    put(PN, 3, 0, 4, 128'h11);
    put(PE, 1, 3, 3, 128'h22);
    put(PS, 3, 6, 2, 128'h33);
    put(PW, 6, 3, 1, 128'h44);
    put(PL, 3, 3, 99, 128'h55);
    want(PS, 3, 0, 4, 128'h11, 1'b0, "R3");
    want(PW, 1, 3, 3, 128'h22, 1'b0, "R3");
    want(PN, 3, 6, 2, 128'h33, 1'b0, "R3");
    want(PE, 6, 3, 1, 128'h44, 1'b0, "R3");
    want_none(PL, "R7");
    launch();

    // R4/R5: older west flit wins east, north flit deflected to north
    put(PN, 6, 3, 5, 128'h61);
    put(PW, 6, 3, 9, 128'h62);
    want(PE, 6, 3, 9, 128'h62, 1'b0, "R4");
    want(PN, 6, 3, 5, 128'h61, 1'b1, "R5");
    want_none(PS, "R4"); want_none(PW, "R4"); want_none(PL, "R4");
    launch();

    // R4: equal ages, north input ranks before south
    put(PN, 6, 3, 7, 128'h71);
    put(PS, 6, 3, 7, 128'h72);
    want(PE, 6, 3, 7, 128'h71, 1'b0, "R4");
    want(PN, 6, 3, 7, 128'h72, 1'b1, "R4");
    want_none(PS, "R4"); want_none(PW, "R4"); want_none(PL, "R4");
    launch();

    // R4: equal ages, west input ranks before local
    put(PW, 6, 3, 7, 128'h81);
    put(PL, 6, 3, 7, 128'h82);
    want(PE, 6, 3, 7, 128'h81, 1'b0, "R4");
    want(PN, 6, 3, 7, 128'h82, 1'b1, "R4");
    want_none(PS, "R4"); want_none(PW, "R4"); want_none(PL, "R4");
    launch();

    // R3/R7: injected flit, north preferred over east
    put(PL, 5, 5, 0, 128'h91);
    want(PN, 5, 5, 0, 128'h91, 1'b0, "R3");
    want_none(PE, "R3"); want_none(PS, "R3"); want_none(PW, "R3"); want_none(PL, "R3");
    launch();

    // R6: two flits for this node plus a passing one
    put(PE, 3, 3, 3, 128'hA1);
    put(PS, 3, 3, 8, 128'hA2);
    put(PW, 0, 3, 1, 128'hA3);
    want(PL, 3, 3, 8, 128'hA2, 1'b0, "R6");
    want(PN, 3, 3, 3, 128'hA1, 1'b1, "R6");
    want(PW, 0, 3, 1, 128'hA3, 1'b0, "R6");
    want_none(PE, "R6"); want_none(PS, "R6");
    launch();

    // R5: all want east, deflection order N, S, W
    put(PN, 6, 3, 20, 128'hB1);
    put(PE, 6, 3, 15, 128'hB2);
    put(PS, 6, 3, 12, 128'hB3);
    put(PW, 6, 3, 10, 128'hB4);
    want(PE, 6, 3, 20, 128'hB1, 1'b0, "R5");
    want(PN, 6, 3, 15, 128'hB2, 1'b1, "R5");
    want(PS, 6, 3, 12, 128'hB3, 1'b1, "R5");
    want(PW, 6, 3, 10, 128'hB4, 1'b1, "R5");
    want_none(PL, "R5");
    launch();

    // R7/R6: three neighbours plus injection addressed here
    put(PN, 3, 6, 1, 128'hC1);
    put(PE, 3, 0, 2, 128'hC2);
    put(PS, 0, 3, 3, 128'hC3);
    put(PL, 3, 3, 50, 128'hC4);
    want(PN, 3, 6, 1, 128'hC1, 1'b0, "R7");
    want(PS, 3, 0, 2, 128'hC2, 1'b0, "R7");
    want(PW, 0, 3, 3, 128'hC3, 1'b0, "R7");
    want(PL, 3, 3, 50, 128'hC4, 1'b0, "R6");
    want_none(PE, "R7");
    launch();

    // R2: back-to-back flits in consecutive cycles
    put(PW, 6, 3, 4, 128'hD1);
    want(PE, 6, 3, 4, 128'hD1, 1'b0, "R2");
    want_none(PN, "R2"); want_none(PS, "R2"); want_none(PW, "R2"); want_none(PL, "R2");
    launch();
    put(PN, 3, 0, 4, 128'hD2);
    want(PS, 3, 0, 4, 128'hD2, 1'b0, "R2");
    want_none(PN, "R2"); want_none(PE, "R2"); want_none(PW, "R2"); want_none(PL, "R2");
    launch();

    repeat (4) @(negedge clk);
    chk("R1", "pending expectations", FW'(q.size()), '0);
    report();
    $finish;
  end
endmodule